// File: doc/BRIEF.md
# Processor Status Flags Write Unit

This block holds a 32-bit processor status-flags word and applies masked updates to it. It has two write paths. A full-width path takes a 32-bit value and a per-bit change mask. A 16-bit legacy path takes a half-word value and two qualifiers: one lets the I/O privilege field change and one lets the interrupt-enable bit change. The set of bits that can be written at all is fixed at elaboration by a CPU-level parameter.

Every accepted write updates the register on the clock edge. In the cycle that follows, one-cycle side-effect strobes report to the rest of the core what the new value requires: a prefetch flush, an asynchronous-event recheck, an alignment-check reevaluation and a mode-change evaluation. A long-mode input keeps the virtual-8086 bit clear and flags any attempt to set it. A lazy-arithmetic marker records that the arithmetic flags are held elsewhere, and any write clears it.

Top module: `status_flags_unit`

## Requirements
- R1: Synchronous active-high reset sets the flags to 0x00000002 and clears every strobe, the error output and the lazy marker.
- R2: A full-width write stores (old & ~m) | (data & m), where m is the change mask ANDed with the supported mask. With the default CPU level 5 the supported mask is 0x003F7FD5; level 4 drops bits 19 and 20, and levels below 4 also drop bits 18 and 21.
- R3: Bit 1 always reads 1; bits 3, 5, 15 and 22 to 31 always read 0.
- R4: A legacy write changes only bits 0, 2, 4, 6, 7, 8, 10 and 11, plus bit 14 when the CPU level is at least 3; bits 16 to 31 keep their values.
- R5: A legacy write changes the privilege field (bits 13:12) only when its privilege qualifier is high and the CPU level is at least 3.
- R6: A legacy write changes the interrupt-enable bit (bit 9) only when its interrupt qualifier is high.
- R7: When both write enables are high in the same cycle, the full-width write is applied and the legacy write is discarded.
- R8: While long mode is high, a write leaves bit 17 at 0; if the merged value had bit 17 set, the error output pulses for one cycle.
- R9: The prefetch-flush strobe pulses for one cycle after a write whose new value has bit 16 set.
- R10: The async-event strobe pulses for one cycle after a write whose new value has bit 8 set.
- R11: The async-event strobe also pulses after a write that takes bit 9 from 0 to 1; a write that leaves bit 9 at 1 does not trigger it by this rule.
- R12: The alignment-recheck and mode-change strobes pulse for exactly one cycle after every accepted write.
- R13: The lazy marker is set by the defer input in a cycle without a write; any write clears it, and a write wins over the defer input in the same cycle.
- R14: In a cycle without a write the flags keep their value and no strobe or error pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| long_mode | input | 1 | Long mode active |
| arith_defer | input | 1 | Arithmetic flags are now held lazily |
| full_we | input | 1 | Full-width write enable |
| full_data | input | 32 | Full-width write value |
| full_mask | input | 32 | Full-width per-bit change mask |
| legacy_we | input | 1 | 16-bit write enable |
| legacy_data | input | 16 | 16-bit write value |
| legacy_iopl_en | input | 1 | Legacy write may change the privilege field |
| legacy_if_en | input | 1 | Legacy write may change the interrupt-enable bit |
| flags | output | 32 | Stored status flags |
| prefetch_inval | output | 1 | Prefetch flush strobe |
| async_event | output | 1 | Asynchronous-event recheck strobe |
| align_recheck | output | 1 | Alignment-check reevaluation strobe |
| mode_change | output | 1 | Mode-change evaluation strobe |
| vm_long_err | output | 1 | Virtual-8086 bit written while in long mode |
| lazy_pending | output | 1 | Arithmetic flags held lazily |

## Verification
The full-width path is driven with an all-ones mask, an all-zero value and single-bit masks: the first shows which bits the level admits, the second that reserved bits hold their fixed values, the last that unmasked bits survive. The legacy path is driven with an all-ones half-word under each qualifier setting, which separates the base mask from the privilege and interrupt gating and shows the upper half untouched. Interrupt-enable writes from 0 and from 1 tell the edge rule apart from a plain level rule, and the virtual-8086 bit is written with and without long mode to separate forcing from the error pulse.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;
  localparam int FLAG_W = 32;
  localparam int LEG_W  = 16;

  localparam int B_TF   = 8;
  localparam int B_IF   = 9;
  localparam int B_IOPL = 12;
  localparam int B_NT   = 14;
  localparam int B_RF   = 16;
  localparam int B_VM   = 17;
  localparam int B_AC   = 18;
  localparam int B_VIF  = 19;
  localparam int B_VIP  = 20;
  localparam int B_ID   = 21;

  localparam logic [FLAG_W-1:0] FIXED_ONES = 32'h0000_0002;
  localparam logic [FLAG_W-1:0] BASE_SUP   = 32'h0003_7fd5;
  localparam logic [FLAG_W-1:0] LEG_BASE   = 32'h0000_0dd5;

  typedef enum logic [1:0] {SRC_NONE, SRC_FULL, SRC_LEGACY} wr_src_e;

  function automatic logic [FLAG_W-1:0] supported_mask(input int level);
    logic [FLAG_W-1:0] m;
    m = BASE_SUP;
    if (level >= 4) begin
      m[B_ID] = 1'b1;
      m[B_AC] = 1'b1;
    end
    if (level >= 5) begin
      m[B_VIP] = 1'b1;
      m[B_VIF] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] legacy_mask(input int level,
                                                    input logic iopl_en,
                                                    input logic if_en);
    logic [FLAG_W-1:0] m;
    m = LEG_BASE;
    if (level >= 3) begin
      m[B_NT] = 1'b1;
      if (iopl_en) m[B_IOPL+:2] = 2'b11;
    end
    if (if_en) m[B_IF] = 1'b1;
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] merge_bits(input logic [FLAG_W-1:0] old_v,
                                                   input logic [FLAG_W-1:0] new_v,
                                                   input logic [FLAG_W-1:0] mask);
    return (old_v & ~mask) | (new_v & mask);
  endfunction
endpackage

// File: rtl/sf_write_select.sv
module sf_write_select
  import status_flags_pkg::*;
#(
  parameter int CPU_LEVEL = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                full_we,
  input  logic [FLAG_W-1:0]   full_data,
  input  logic [FLAG_W-1:0]   full_mask,
  input  logic                legacy_we,
  input  logic [LEG_W-1:0]    legacy_data,
  input  logic                legacy_iopl_en,
  input  logic                legacy_if_en,
  output logic                wr_any,
  output wr_src_e             wr_src,
  output logic [FLAG_W-1:0]   eff_data,
  output logic [FLAG_W-1:0]   eff_mask
);
  localparam logic [FLAG_W-1:0] SUP = supported_mask(CPU_LEVEL);

  always_comb begin
    wr_src   = SRC_NONE;
    eff_data = '0;
    eff_mask = '0;
    if (full_we) begin
      wr_src   = SRC_FULL;
      eff_data = full_data;
      eff_mask = full_mask & SUP;
    end else if (legacy_we) begin
      wr_src   = SRC_LEGACY;
      eff_data = {{(FLAG_W-LEG_W){1'b0}}, legacy_data};
      eff_mask = legacy_mask(CPU_LEVEL, legacy_iopl_en, legacy_if_en) & SUP;
    end
  end

  assign wr_any = (wr_src != SRC_NONE);

  // R4
  legacy_upper_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_src == SRC_LEGACY) |-> (eff_mask[FLAG_W-1:LEG_W] == '0));

  // R7
  full_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (full_we && legacy_we) |-> (wr_src == SRC_FULL));
endmodule

// File: rtl/sf_side_effects.sv
module sf_side_effects
  import status_flags_pkg::*;
(
  input  logic                wr_any,
  input  logic                long_mode,
  input  logic [FLAG_W-1:0]   old_flags,
  input  logic [FLAG_W-1:0]   merged,
  output logic [FLAG_W-1:0]   next_flags,
  output logic                ev_inval,
  output logic                ev_async,
  output logic                ev_vm_err
);
  logic if_rise;

  always_comb begin
    next_flags = merged;
    if (long_mode) next_flags[B_VM] = 1'b0;
    next_flags = next_flags | FIXED_ONES;
  end

  assign if_rise   = next_flags[B_IF] & ~old_flags[B_IF];
  assign ev_inval  = wr_any & next_flags[B_RF];
  assign ev_async  = wr_any & (next_flags[B_TF] | if_rise);
  assign ev_vm_err = wr_any & long_mode & merged[B_VM];
endmodule

// File: rtl/status_flags_unit.sv
module status_flags_unit
  import status_flags_pkg::*;
#(
  parameter int CPU_LEVEL = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        long_mode,
  input  logic        arith_defer,
  input  logic        full_we,
  input  logic [31:0] full_data,
  input  logic [31:0] full_mask,
  input  logic        legacy_we,
  input  logic [15:0] legacy_data,
  input  logic        legacy_iopl_en,
  input  logic        legacy_if_en,
  output logic [31:0] flags,
  output logic        prefetch_inval,
  output logic        async_event,
  output logic        align_recheck,
  output logic        mode_change,
  output logic        vm_long_err,
  output logic        lazy_pending
);
  localparam logic [FLAG_W-1:0] SUP = supported_mask(CPU_LEVEL);
  localparam logic [FLAG_W-1:0] CONST_BITS = ~SUP;

  logic              wr_any;
  wr_src_e           wr_src;
  logic [FLAG_W-1:0] eff_data, eff_mask, merged, next_flags;
  logic              ev_inval, ev_async, ev_vm_err;

  sf_write_select #(.CPU_LEVEL(CPU_LEVEL)) u_sel (
    .clk(clk), .rst(rst),
    .full_we(full_we), .full_data(full_data), .full_mask(full_mask),
    .legacy_we(legacy_we), .legacy_data(legacy_data),
    .legacy_iopl_en(legacy_iopl_en), .legacy_if_en(legacy_if_en),
    .wr_any(wr_any), .wr_src(wr_src), .eff_data(eff_data), .eff_mask(eff_mask)
  );

  assign merged = merge_bits(flags, eff_data, eff_mask);

  sf_side_effects u_fx (
    .wr_any(wr_any), .long_mode(long_mode),
    .old_flags(flags), .merged(merged), .next_flags(next_flags),
    .ev_inval(ev_inval), .ev_async(ev_async), .ev_vm_err(ev_vm_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags          <= FIXED_ONES;
      prefetch_inval <= 1'b0;
      async_event    <= 1'b0;
      align_recheck  <= 1'b0;
      mode_change    <= 1'b0;
      vm_long_err    <= 1'b0;
      lazy_pending   <= 1'b0;
    end else begin
      if (wr_any) flags <= next_flags;
      prefetch_inval <= ev_inval;
      async_event    <= ev_async;
      align_recheck  <= wr_any;
      mode_change    <= wr_any;
      vm_long_err    <= ev_vm_err;
      if (wr_any)           lazy_pending <= 1'b0;
      else if (arith_defer) lazy_pending <= 1'b1;
    end
  end

  // R3
  reserved_bits_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags & CONST_BITS) == FIXED_ONES));

  // R2
  unsupported_stable_chk: assert property (@(posedge clk) disable iff (rst)
    full_we |=> ((flags & CONST_BITS) == ($past(flags) & CONST_BITS)));

  // R8
  long_vm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_any && long_mode) |=> !flags[B_VM]);

  // R11
  if_rise_async_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_any && !flags[B_IF] && merged[B_IF]) |=> async_event);

  // R12
  write_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> (align_recheck && mode_change));

  // R13
  lazy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_any |=> !lazy_pending);

  // R14
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_any |=> ($stable(flags) && !prefetch_inval && !async_event &&
                 !align_recheck && !mode_change && !vm_long_err));
endmodule

// File: tb/status_flags_unit_tb.sv
module status_flags_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        long_mode = 1'b0, arith_defer = 1'b0;
  logic        full_we = 1'b0, legacy_we = 1'b0;
  logic [31:0] full_data = '0, full_mask = '0;
  logic [15:0] legacy_data = '0;
  logic        legacy_iopl_en = 1'b0, legacy_if_en = 1'b0;
  logic [31:0] flags;
  logic        prefetch_inval, async_event, align_recheck, mode_change, vm_long_err, lazy_pending;

  int n_chk = 0, n_bad = 0;
  logic [31:0] ref_flags = 32'h2;
  logic        ref_lazy = 1'b0;

  always #2 clk = ~clk;

  status_flags_unit u_dut (
    .clk(clk), .rst(rst), .long_mode(long_mode), .arith_defer(arith_defer),
    .full_we(full_we), .full_data(full_data), .full_mask(full_mask),
    .legacy_we(legacy_we), .legacy_data(legacy_data),
    .legacy_iopl_en(legacy_iopl_en), .legacy_if_en(legacy_if_en),
    .flags(flags), .prefetch_inval(prefetch_inval), .async_event(async_event),
    .align_recheck(align_recheck), .mode_change(mode_change),
    .vm_long_err(vm_long_err), .lazy_pending(lazy_pending)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One cycle of stimulus; caller is at a falling edge.
  task automatic step(input string req, input logic fw, input logic [31:0] fd, input logic [31:0] fm,
                      input logic lw, input logic [15:0] ld, input logic io, input logic ie,
                      input logic lm, input logic df);
    logic [31:0] m, v, nv;
    logic wr, e_inv, e_async, e_err;
    full_we = fw; full_data = fd; full_mask = fm;
    legacy_we = lw; legacy_data = ld; legacy_iopl_en = io; legacy_if_en = ie;
    long_mode = lm; arith_defer = df;
    wr = fw | lw;
    // writable set at level 5: CF PF AF ZF SF TF IF DF OF IOPL NT RF VM AC VIF VIP ID
    if (fw) begin m = fm & 32'h003f_7fd5; v = fd; end
    else if (lw) begin
      m = 32'h0000_4dd5;
      if (io) m = m | 32'h3000;
      if (ie) m = m | 32'h0200;
      v = {16'h0, ld};
    end else begin m = '0; v = '0; end
    nv = (ref_flags & ~m) | (v & m);
    e_err = wr & lm & nv[17];
    if (lm) nv[17] = 1'b0;
    nv = nv | 32'h2;
    e_inv = wr & nv[16];
    e_async = wr & (nv[8] | (nv[9] & ~ref_flags[9]));
    if (wr) ref_flags = nv;
    if (wr) ref_lazy = 1'b0; else if (df) ref_lazy = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk({req, " flags"}, flags, ref_flags);
    chk({req, " inval"}, {31'b0, prefetch_inval}, {31'b0, e_inv});
    chk({req, " async"}, {31'b0, async_event}, {31'b0, e_async});
    chk({req, " strobes"}, {30'b0, align_recheck, mode_change}, {30'b0, wr, wr});
    chk({req, " vmerr"}, {31'b0, vm_long_err}, {31'b0, e_err});
    chk({req, " lazy"}, {31'b0, lazy_pending}, {31'b0, ref_lazy});
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 32'h2);
    chk("R1 outs", {26'b0, prefetch_inval, async_event, align_recheck, mode_change, vm_long_err, lazy_pending}, 32'h0);
  endtask

  task automatic t_full;
    step("R2 all-ones", 1, 32'hffff_ffff, 32'hffff_ffff, 0, 0, 0, 0, 0, 0);
    chk("R2 value", flags, 32'h003f_7fd7);
    step("R3 all-zero", 1, 32'h0, 32'hffff_ffff, 0, 0, 0, 0, 0, 0);
    chk("R3 value", flags, 32'h2);
    step("R2 single CF", 1, 32'hffff_ffff, 32'h1, 0, 0, 0, 0, 0, 0);
    chk("R2 cf only", flags, 32'h3);
    step("R9 rf", 1, 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 0, 0, 0);
    step("R10 tf", 1, 32'h0000_0100, 32'h0000_0100, 0, 0, 0, 0, 0, 0);
    step("R10 tf clear", 1, 32'h0, 32'h0001_0101, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_if_edge;
    step("R11 if rise", 1, 32'h200, 32'h200, 0, 0, 0, 0, 0, 0);
    chk("R11 rise async", {31'b0, async_event}, 32'h1);
    step("R11 if hold", 1, 32'h200, 32'h200, 0, 0, 0, 0, 0, 0);
    chk("R11 hold no async", {31'b0, async_event}, 32'h0);
    step("R11 if clear", 1, 32'h0, 32'h200, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_legacy;
    step("R4 set ID", 1, 32'h0020_0000, 32'h0020_0000, 0, 0, 0, 0, 0, 0);
    step("R4 legacy base", 0, 0, 0, 1, 16'hffff, 0, 0, 0, 0);
    chk("R4 base value", flags, 32'h0020_4dd7);
    step("R5 iopl on", 0, 0, 0, 1, 16'h3000, 1, 0, 0, 0);
    chk("R5 iopl set", flags, 32'h0020_3002);
    step("R5 iopl off", 0, 0, 0, 1, 16'h0000, 0, 0, 0, 0);
    chk("R5 iopl kept", flags, 32'h0020_3002);
    step("R6 if off", 0, 0, 0, 1, 16'h0200, 0, 0, 0, 0);
    chk("R6 if unchanged", flags[9], 1'b0);
    step("R6 if on", 0, 0, 0, 1, 16'h0200, 0, 1, 0, 0);
    chk("R6 if set", flags, 32'h0020_3202);
  endtask

  task automatic t_both;
    step("R7 both", 1, 32'h0000_0001, 32'h0000_0001, 1, 16'h0080, 0, 0, 0, 0);
    chk("R7 full wins", flags[7:0], 8'h03);
  endtask

  task automatic t_long;
    step("R8 vm long", 1, 32'h0002_0000, 32'h0002_0000, 0, 0, 0, 0, 1, 0);
    chk("R8 err", {31'b0, vm_long_err}, 32'h1);
    step("R8 vm legacy", 1, 32'h0002_0000, 32'h0002_0000, 0, 0, 0, 0, 0, 0);
    chk("R8 vm set", flags[17], 1'b1);
    step("R8 clear in long", 1, 32'h0, 32'h0000_0001, 0, 0, 0, 0, 1, 0);
    chk("R8 forced", flags[17], 1'b0);
  endtask

  task automatic t_lazy_idle;
    step("R13 defer", 0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R13 set", {31'b0, lazy_pending}, 32'h1);
    step("R14 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R13 write wins", 1, 32'h1, 32'h1, 0, 0, 0, 0, 0, 1);
    chk("R13 cleared", {31'b0, lazy_pending}, 32'h0);
    step("R12 back to idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_full();
    t_if_edge();
    t_legacy();
    t_both();
    t_long();
    t_lazy_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule